// File: doc/BRIEF.md
# Pin Controller with Level-Match Interrupt Capture

This block manages a bank of general-purpose pins on behalf of software. Each pin is either kept as a software-controlled pin or handed to an alternate-function signal that comes from elsewhere in the chip. A software-controlled pin has its own direction and output value. Its sampled input state can always be read back through a small word-addressed register port.

Every pin also has a programmable match level. Whenever the synchronised pin value equals that level, a per-pin capture bit is set. The bit stays set until software overwrites it. A separate enable mask selects which capture bits can raise the single non-maskable interrupt output. Pad drivers sit outside the block, and so do the bus bridge and any ordinary maskable interrupt controller. The block drives pin value and output-enable vectors toward the pads and reads back a raw pin input vector.

Top module: `gpio_level_irq`

## Requirements
- R1: While reset is asserted and directly after it, every register reads zero. Every pin is an input in software mode (`pinOe` all zero), and `nmiOut` is low.
- R2: Word registers sit at byte offsets 0x00 (mode select), 0x04 (direction), 0x08 (data), 0x0C (match level), 0x10 (capture status) and 0x14 (interrupt enable). `busRdata` shows the addressed register combinationally. A write with `busSel` and `busWrite` high takes effect at the next rising clock edge.
- R3: A read from any other address returns zero, including misaligned addresses where the low two bits are not 00. A write to such an address changes no register.
- R4: For a pin whose mode bit is 0, `pinOut` carries its data-register bit and `pinOe` carries its direction bit (1 = output, 0 = input).
- R5: For a pin whose mode bit is 1, `pinOut` and `pinOe` follow `altOut` and `altOe`, whatever the direction and data bits hold.
- R6: Reading offset 0x08 returns `pinIn` after two synchronising flops. A change on `pinIn` becomes visible after the second rising edge.
- R7: A capture bit is set at the rising edge after the synchronised pin value equals that pin's match-level bit, which is the third edge after a change on `pinIn`.
- R8: A set capture bit stays set after the pin stops matching, until the status register is written.
- R9: Writing offset 0x10 loads the written word into the capture bits, so a 0 clears and a 1 sets. When a match and a write hit the same bit in the same cycle, the match wins and the bit ends up set.
- R10: `nmiOut` is high exactly when some pin has both its capture bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| pinIn | input | 32 | Raw pin inputs from the pads |
| pinOut | output | 32 | Values driven toward the pads |
| pinOe | output | 32 | Per-pin output enable toward the pads |
| altOut | input | 32 | Alternate-function output values |
| altOe | input | 32 | Alternate-function output enables |
| nmiOut | output | 1 | Non-maskable interrupt request |

## Verification
The hardest case to reach is a status write that lands in the same cycle as a live match. Synchronised input, match level and write must all line up, or the test proves nothing. The bench first holds a pin steady at its match level for more than three edges, so the match is continuously present. It then writes zero to the status word and expects that bit to survive while a neighbouring bit with no match is cleared. The bench models the pads so that output pins loop back onto `pinIn`, and it counts edges from each input change to find the exact cycle where readback and capture must first change.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;

  typedef enum logic [2:0] {
    RD_MODE  = 3'd0,
    RD_DIR   = 3'd1,
    RD_DATA  = 3'd2,
    RD_LEVEL = 3'd3,
    RD_STAT  = 3'd4,
    RD_NMIEN = 3'd5,
    RD_NONE  = 3'd6
  } rdSelE;

  typedef struct packed {
    logic  wrMode;
    logic  wrDir;
    logic  wrData;
    logic  wrLevel;
    logic  wrStat;
    logic  wrNmien;
    rdSelE rdSel;
  } strobeS;

endpackage

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeS            strobes
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_MODE  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_DIR   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LEVEL = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_STAT  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_NMIEN = IDX_W'(5);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             doWrite;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWrite = busSel && busWrite && aligned;

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    if (aligned) begin
      unique case (wordIdx)
        IDX_MODE:  begin strobes.rdSel = RD_MODE;  strobes.wrMode  = doWrite; end
        IDX_DIR:   begin strobes.rdSel = RD_DIR;   strobes.wrDir   = doWrite; end
        IDX_DATA:  begin strobes.rdSel = RD_DATA;  strobes.wrData  = doWrite; end
        IDX_LEVEL: begin strobes.rdSel = RD_LEVEL; strobes.wrLevel = doWrite; end
        IDX_STAT:  begin strobes.rdSel = RD_STAT;  strobes.wrStat  = doWrite; end
        IDX_NMIEN: begin strobes.rdSel = RD_NMIEN; strobes.wrNmien = doWrite; end
        default:   strobes.rdSel = RD_NONE;
      endcase
    end
  end

  // At most one register is written per access
  always_comb begin
    AST_ONE_WRITE: assert ($onehot0({strobes.wrMode, strobes.wrDir, strobes.wrData,
                                     strobes.wrLevel, strobes.wrStat, strobes.wrNmien})); // R2
  end

  // A misaligned access never selects a register
  always_comb begin
    AST_MISALIGNED: assert (aligned || strobes.rdSel == RD_NONE); // R3
  end

endmodule

// File: rtl/gpio_lvl_datapath.sv
module gpio_lvl_datapath
  import gpio_lvl_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeS              strobes,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] altOut,
  input  logic [NUM_PINS-1:0] altOe,
  output logic                nmiOut
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] modeQ, dirQ, dataQ, levelQ, statQ, nmienQ;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinNow;
  logic [NUM_PINS-1:0] matchVec;

  // Input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinNow   = syncQ[LAST_STAGE];
  assign matchVec = ~(pinNow ^ levelQ);

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      dirQ   <= '0;
      dataQ  <= '0;
      levelQ <= '0;
      nmienQ <= '0;
    end else begin
      if (strobes.wrMode)  modeQ  <= busWdata;
      if (strobes.wrDir)   dirQ   <= busWdata;
      if (strobes.wrData)  dataQ  <= busWdata;
      if (strobes.wrLevel) levelQ <= busWdata;
      if (strobes.wrNmien) nmienQ <= busWdata;
    end
  end

  // Sticky capture: a live match overrides a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (strobes.wrStat ? busWdata : statQ) | matchVec;
  end

  // Per-pin ownership mux
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    assign pinOut[p] = modeQ[p] ? altOut[p] : dataQ[p];
    assign pinOe[p]  = modeQ[p] ? altOe[p]  : dirQ[p];
  end

  assign nmiOut = |(statQ & nmienQ);

  always_comb begin
    unique case (strobes.rdSel)
      RD_MODE:  busRdata = modeQ;
      RD_DIR:   busRdata = dirQ;
      RD_DATA:  busRdata = pinNow;
      RD_LEVEL: busRdata = levelQ;
      RD_STAT:  busRdata = statQ;
      RD_NMIEN: busRdata = nmienQ;
      default:  busRdata = '0;
    endcase
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec != '0) |=> ((statQ & $past(matchVec)) == $past(matchVec))); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrStat |=> ((statQ & $past(statQ)) == $past(statQ))); // R8

  AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (nmienQ == '0) |-> !nmiOut); // R10

  AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    ((~modeQ & ~dirQ & pinOe) == '0)); // R4

endmodule

// File: rtl/gpio_level_irq.sv
module gpio_level_irq
  import gpio_lvl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] altOut,
  input  logic [NUM_PINS-1:0] altOe,
  output logic                nmiOut
);
  strobeS strobes;

  gpio_lvl_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_lvl_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(2)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .altOut  (altOut),
    .altOe   (altOe),
    .nmiOut  (nmiOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rstN) |-> (pinOe == '0 && !nmiOut)); // R1

endmodule

// File: tb/tb_gpio_level_irq.sv
`timescale 1ns/1ps
module tb_gpio_level_irq;
  localparam int NP = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [NP-1:0] busWdata = '0, busRdata;
  logic [NP-1:0] pinIn, pinOut, pinOe;
  logic [NP-1:0] altOut = '0, altOe = '0;
  logic [NP-1:0] extDrive = '0;
  logic          nmiOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // Pad model: driven pins loop back, others follow the external level
  assign pinIn = (pinOe & pinOut) | (~pinOe & extDrive);

  gpio_level_irq #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altOut(altOut), .altOe(altOe), .nmiOut(nmiOut)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write commits on the posedge between two negedges
  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  // Combinational read without consuming a clock
  task automatic peek(input logic [AW-1:0] a, output logic [NP-1:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    logic [NP-1:0] v;
    edges(2);
    peek(8'h00, v); check("R1 mode", v, '0);
    peek(8'h04, v); check("R1 dir", v, '0);
    peek(8'h10, v); check("R1 status", v, '0);
    peek(8'h14, v); check("R1 enable", v, '0);
    check("R1 pinOe", pinOe, '0);
    check("R1 nmi", {31'd0, nmiOut}, '0);
    @(negedge clk); rstN = 1'b1;
    check("R1 pinOe after release", pinOe, '0);
  endtask

  task automatic tRegAccess();
    logic [NP-1:0] v;
    wr(8'h00, 32'h1234_5678); peek(8'h00, v); check("R2 mode", v, 32'h1234_5678);
    wr(8'h04, 32'h8765_4321); peek(8'h04, v); check("R2 dir", v, 32'h8765_4321);
    wr(8'h0C, 32'hDEAD_BEEF); peek(8'h0C, v); check("R2 level", v, 32'hDEAD_BEEF);
    wr(8'h14, 32'h0000_0000); peek(8'h14, v); check("R2 enable", v, 32'h0);
    wr(8'h00, '0); wr(8'h04, '0); wr(8'h0C, '0);
  endtask

  task automatic tUnmapped();
    logic [NP-1:0] v;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    peek(8'h18, v); check("R3 read 0x18", v, '0);
    peek(8'h02, v); check("R3 read 0x02", v, '0);
    peek(8'hFC, v); check("R3 read 0xFC", v, '0);
    peek(8'h00, v); check("R3 mode untouched", v, '0);
    peek(8'h04, v); check("R3 dir untouched", v, '0);
  endtask

  task automatic tGpioOut();
    logic [NP-1:0] v;
    extDrive = '0;
    wr(8'h04, 32'h0000_00FF);
    wr(8'h08, 32'hA5A5_00C3);
    check("R4 pinOe", pinOe, 32'h0000_00FF);
    check("R4 pinOut", pinOut, 32'hA5A5_00C3);
    edges(2);
    peek(8'h08, v); check("R6 loopback read", v, 32'h0000_00C3);
  endtask

  task automatic tAltFunc();
    altOut = 32'h0F0F_0000; altOe = 32'hFFFF_0000;
    wr(8'h00, 32'hFFFF_0000);
    check("R5 pinOe", pinOe, 32'hFFFF_00FF);
    check("R5 pinOut", pinOut, 32'h0F0F_00C3);
    altOut = 32'h00F0_0000; altOe = 32'h0000_0000; #1;
    check("R5 follows altOe", pinOe, 32'h0000_00FF);
    check("R5 follows altOut", pinOut, 32'h00F0_00C3);
    wr(8'h00, '0); wr(8'h04, '0); wr(8'h08, '0);
    altOut = '0; altOe = '0;
  endtask

  task automatic tSyncCapture();
    logic [NP-1:0] v;
    wr(8'h0C, 32'hFFFF_FFFF);
    edges(3);
    wr(8'h10, 32'h0);
    edges(1);
    peek(8'h10, v); check("R7 no match no status", v, '0);
    extDrive[5] = 1'b1;                  // change at a negedge
    edges(1);
    peek(8'h08, v); check("R6 not yet after edge1", v, '0);
    edges(1);
    peek(8'h08, v); check("R6 visible after edge2", v, 32'h0000_0020);
    peek(8'h10, v); check("R7 status not yet after edge2", v, '0);
    edges(1);
    peek(8'h10, v); check("R7 status set after edge3", v, 32'h0000_0020);
    extDrive[5] = 1'b0;
    edges(4);
    peek(8'h10, v); check("R8 sticky after pin drops", v, 32'h0000_0020);
  endtask

  task automatic tStatusWrite();
    logic [NP-1:0] v;
    wr(8'h10, 32'h0);
    peek(8'h10, v); check("R9 write zero clears", v, '0);
    wr(8'h10, 32'h0000_0100);
    peek(8'h10, v); check("R9 write one loads", v, 32'h0000_0100);
    extDrive[7] = 1'b1;
    edges(4);
    wr(8'h10, 32'h0);                   // match still live on bit 7
    peek(8'h10, v); check("R9 match beats clear", v, 32'h0000_0080);
  endtask

  task automatic tNmi();
    logic [NP-1:0] v;
    check("R10 no enable", {31'd0, nmiOut}, 32'd0);
    wr(8'h14, 32'h0000_0100);
    check("R10 enable on clear bit", {31'd0, nmiOut}, 32'd0);
    wr(8'h14, 32'h0000_0080);
    check("R10 enable on set bit", {31'd0, nmiOut}, 32'd1);
    extDrive[7] = 1'b0;
    edges(3);
    wr(8'h10, 32'h0);
    peek(8'h10, v); check("R10 status cleared", v, '0);
    check("R10 nmi drops", {31'd0, nmiOut}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tReset();
    tRegAccess();
    tUnmapped();
    tGpioOut();
    tAltFunc();
    tSyncCapture();
    tStatusWrite();
    tNmi();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule